// File: doc/BRIEF.md
# DRAM Refresh and Start-Up Sequencer

This block brings a fast-page-mode DRAM from power-on to a usable state and then keeps its rows alive. After reset it counts out the power-up pause. It then runs a burst of wake-up cycles and only afterwards raises `ready`, which tells the access controller that normal traffic may start. From then on an interval timer adds one owed refresh per period. Every refresh, whether in the wake-up burst or in normal running, is a CAS-before-RAS cycle, so the memory supplies its own row address and no row counter is driven from here.

The sequencer shares the strobes with the access controller through a level request/grant handshake. It raises `ref_req` while work is pending. Once `ref_gnt` is seen, it takes the strobes (`bus_own` high) and drives RAS and CAS directly. While `bus_own` is high the controller keeps its data pins in high impedance and leaves WE, OE and address alone. Refreshes that pile up while the grant is withheld are issued back-to-back under one grant. If the backlog limit is exceeded, the refresh deadline counts as missed: `ready` drops and the whole wake-up burst is repeated.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ref_req`, `bus_own` and `ready` are low and `ras_n`, `cas_n` are high.
- R2: `ref_req` stays low for at least PAUSE_CYC cycles after reset is released and rises no later than PAUSE_CYC+4 cycles after it.
- R3: After the pause, exactly WAKE_CNT refresh cycles are issued back-to-back without `ref_req` falling, and `ready` rises only when the last of them has completed.
- R4: In every refresh cycle `cas_n` falls first, stays low for at least CSR_CYC cycles before `ras_n` falls, and stays low for as long as `ras_n` is low; `ras_n` is never low while `cas_n` is high.
- R5: `ras_n` stays low for exactly RAS_CYC cycles per refresh, and it stays high for at least RP_CYC cycles before it falls again.
- R6: While `bus_own` is low, `ras_n` and `cas_n` are high; a grant with no request pending has no effect on any output.
- R7: Before every fall of `cas_n`, `cas_n` has been high for at least CP_CYC cycles, including the first cycle after the grant arrives.
- R8: In normal running, one refresh becomes owed every INTERVAL_CYC cycles, so with the grant always available the RAS falls are exactly INTERVAL_CYC cycles apart. Refreshes owed while the grant is withheld, up to MAX_OWED of them, are all issued back-to-back under the next grant, and `ref_req` falls once none remains.
- R9: If a period ends while MAX_OWED refreshes are already owed, `ready` falls, the backlog is dropped, and exactly WAKE_CNT refresh cycles must complete before `ready` rises again.
- R10: `bus_own` rises only in the cycle after `ref_gnt` was high, and the sequencer never drives the strobes while it holds no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_req | output | 1 | Refresh or wake-up work is pending, or a cycle is in progress |
| ref_gnt | input | 1 | Access controller yields the strobes; held until `ref_req` falls |
| bus_own | output | 1 | The sequencer drives the strobes; the controller keeps data pins high-Z |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ready | output | 1 | Initialization is complete and no re-wake is in progress |

## Verification
The assertions are checked on every cycle. They cover the strobe ordering, so that RAS only falls under a CAS that was already low and RAS is never low alone. They also cover the strobes resting high while the bus is not owned, ownership starting only after a grant, silence during the pause, and the backlog bound. Some behaviour can only be shown by the bench's scenarios, because it depends on a history of grant patterns: the exact pause length, the wake-up count before `ready`, the spacing of periodic refreshes, draining of an accumulated backlog, and the deadline-miss recovery. The bench watches the pins and also measures the pulse widths and precharge gaps against their cycle limits.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
  typedef enum logic [1:0] {M_PAUSE, M_WAKE, M_RUN} mode_t;
  typedef enum logic [2:0] {E_IDLE, E_HOLD, E_SETUP, E_ACT, E_PRE} eng_t;
endpackage

// File: rtl/dram_rfsh_timer.sv
module dram_rfsh_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/dram_rfsh_ledger.sv
module dram_rfsh_ledger
  import dram_rfsh_pkg::*;
#(
  parameter int WAKE_CNT = 8,
  parameter int MAX_OWED = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  pause_tick,
  input  logic  ivl_tick,
  input  logic  cyc_start,
  input  logic  cyc_done,
  output mode_t mode,
  output logic  work,
  output logic  ready
);
  localparam int WW = $clog2(WAKE_CNT + 1);
  localparam int OW = $clog2(MAX_OWED + 1);
  localparam logic [WW-1:0] WAKE_LOAD = WW'(WAKE_CNT);
  localparam logic [OW-1:0] OWED_TOP  = OW'(MAX_OWED);

  logic [WW-1:0] wake_left;
  logic [OW-1:0] owed;
  logic          cur_wake;
  logic          wake_dec, run_dec, miss;

  assign wake_dec = cyc_done && cur_wake && (mode == M_WAKE);
  assign run_dec  = cyc_done && !cur_wake && (mode == M_RUN);
  assign miss     = (mode == M_RUN) && ivl_tick && !run_dec && (owed == OWED_TOP);
  assign work     = ((mode == M_WAKE) && (wake_left != '0)) ||
                    ((mode == M_RUN) && (owed != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= M_PAUSE;
      wake_left <= '0;
      owed      <= '0;
      cur_wake  <= 1'b0;
      ready     <= 1'b0;
    end else begin
      if (cyc_start) cur_wake <= (mode == M_WAKE);
      case (mode)
        M_PAUSE: if (pause_tick) begin
          mode      <= M_WAKE;
          wake_left <= WAKE_LOAD;
        end
        M_WAKE: if (wake_dec) begin
          if (wake_left == WW'(1)) begin
            mode      <= M_RUN;
            ready     <= 1'b1;
            wake_left <= '0;
          end else begin
            wake_left <= wake_left - 1'b1;
          end
        end
        default: begin
          if (miss) begin
            mode      <= M_WAKE;
            wake_left <= WAKE_LOAD;
            owed      <= '0;
            ready     <= 1'b0;
          end else if (ivl_tick && !run_dec) begin
            owed <= owed + 1'b1;
          end else if (!ivl_tick && run_dec) begin
            owed <= owed - 1'b1;
          end
        end
      endcase
    end
  end

  // R8: the backlog never grows past its bound
  a_r8_owed_cap: assert property (@(posedge clk) disable iff (rst)
    owed <= OWED_TOP);
endmodule

// File: rtl/dram_cbr_engine.sv
module dram_cbr_engine
  import dram_rfsh_pkg::*;
#(
  parameter int CP_CYC  = 2,
  parameter int CSR_CYC = 2,
  parameter int RAS_CYC = 5,
  parameter int RP_CYC  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic work,
  input  logic gnt,
  output logic req,
  output logic bus_own,
  output logic ras_n,
  output logic cas_n,
  output logic cyc_start,
  output logic cyc_done
);
  localparam int M1   = (CP_CYC > CSR_CYC) ? CP_CYC : CSR_CYC;
  localparam int M2   = (RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int W    = $clog2(MAXC + 1);

  eng_t st, st_n;
  logic [W-1:0] cnt, cnt_n;

  always_comb begin
    st_n      = st;
    cnt_n     = (cnt == '0) ? '0 : cnt - 1'b1;
    cyc_start = 1'b0;
    cyc_done  = 1'b0;
    case (st)
      E_IDLE: if (work && gnt) begin
        st_n  = E_HOLD;
        cnt_n = W'(CP_CYC - 1);
      end
      E_HOLD: if (cnt == '0) begin
        st_n      = E_SETUP;
        cnt_n     = W'(CSR_CYC - 1);
        cyc_start = 1'b1;
      end
      E_SETUP: if (cnt == '0) begin
        st_n  = E_ACT;
        cnt_n = W'(RAS_CYC - 1);
      end
      E_ACT: if (cnt == '0) begin
        st_n     = E_PRE;
        cnt_n    = W'(RP_CYC - 1);
        cyc_done = 1'b1;
      end
      default: if (cnt == '0) begin
        if (work && gnt) begin
          st_n      = E_SETUP;
          cnt_n     = W'(CSR_CYC - 1);
          cyc_start = 1'b1;
        end else begin
          st_n = E_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= E_IDLE;
      cnt     <= '0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      bus_own <= 1'b0;
      req     <= 1'b0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      ras_n   <= (st_n != E_ACT);
      cas_n   <= !((st_n == E_SETUP) || (st_n == E_ACT));
      bus_own <= (st_n != E_IDLE);
      req     <= work || (st_n != E_IDLE);
    end
  end

  // R4: RAS only falls under a CAS that was already low
  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $past(!cas_n));
  // R4: RAS is never low on its own
  a_r4_cas_covers_ras: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> !cas_n);
  // R6: strobes rest high whenever the bus is not owned
  a_r6_idle_strobes: assert property (@(posedge clk) disable iff (rst)
    !bus_own |-> (ras_n && cas_n));
  // R10: ownership starts only after a grant
  a_r10_own_after_gnt: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_own) |-> $past(gnt));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int PAUSE_CYC    = 25000,
  parameter int INTERVAL_CYC = 1950,
  parameter int WAKE_CNT     = 8,
  parameter int MAX_OWED     = 8,
  parameter int CP_CYC       = 2,
  parameter int CSR_CYC      = 2,
  parameter int RAS_CYC      = 5,
  parameter int RP_CYC       = 3
) (
  input  logic clk,
  input  logic rst,
  output logic ref_req,
  input  logic ref_gnt,
  output logic bus_own,
  output logic ras_n,
  output logic cas_n,
  output logic ready
);
  mode_t mode;
  logic  pause_tick, ivl_tick, work, cyc_start, cyc_done;

  dram_rfsh_timer #(.LIMIT(PAUSE_CYC)) pause_tmr_i (
    .clk(clk), .rst(rst), .en(mode == M_PAUSE), .tick(pause_tick));

  dram_rfsh_timer #(.LIMIT(INTERVAL_CYC)) ivl_tmr_i (
    .clk(clk), .rst(rst), .en(mode == M_RUN), .tick(ivl_tick));

  dram_rfsh_ledger #(.WAKE_CNT(WAKE_CNT), .MAX_OWED(MAX_OWED)) ledger_i (
    .clk(clk), .rst(rst), .pause_tick(pause_tick), .ivl_tick(ivl_tick),
    .cyc_start(cyc_start), .cyc_done(cyc_done),
    .mode(mode), .work(work), .ready(ready));

  dram_cbr_engine #(.CP_CYC(CP_CYC), .CSR_CYC(CSR_CYC),
                    .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)) engine_i (
    .clk(clk), .rst(rst), .work(work), .gnt(ref_gnt),
    .req(ref_req), .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n),
    .cyc_start(cyc_start), .cyc_done(cyc_done));

  // R2: nothing is requested while the power-up pause runs
  a_r2_quiet_in_pause: assert property (@(posedge clk) disable iff (rst)
    (mode == M_PAUSE) |-> !ref_req);
endmodule

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;
  localparam int PAUSE = 100, IVL = 80, WAKE = 8, MAXO = 3;
  localparam int CP = 2, CSR = 2, RASW = 5, RP = 3;

  logic clk = 1'b0, rst = 1'b1, ref_gnt = 1'b0;
  logic ref_req, bus_own, ras_n, cas_n, ready;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dram_refresh_seq #(.PAUSE_CYC(PAUSE), .INTERVAL_CYC(IVL), .WAKE_CNT(WAKE),
    .MAX_OWED(MAXO), .CP_CYC(CP), .CSR_CYC(CSR), .RAS_CYC(RASW), .RP_CYC(RP)) dut_i (
    .clk(clk), .rst(rst), .ref_req(ref_req), .ref_gnt(ref_gnt), .bus_own(bus_own),
    .ras_n(ras_n), .cas_n(cas_n), .ready(ready));

  // pin monitor
  int cyc = 0, cbr_cnt = 0, req_falls = 0, last_fall = 0, spacing = 0;
  int v_csr = 0, v_ras = 0, v_rp = 0, v_cp = 0, v_lone = 0;
  int ras_lo = 0, ras_hi = 0, cas_lo = 0, cas_hi = 0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_req = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (p_ras && !ras_n) begin
        if (!cas_n) cbr_cnt++;
        if (cas_lo < CSR) v_csr++;
        if (ras_hi < RP) v_rp++;
        spacing = cyc - last_fall;
        last_fall = cyc;
      end
      if (!p_ras && ras_n && ras_lo != RASW) v_ras++;
      if (p_cas && !cas_n && cas_hi < CP) v_cp++;
      if (!ras_n && cas_n) v_lone++;
      if (p_req && !ref_req) req_falls++;
    end
    ras_lo = ras_n ? 0 : ras_lo + 1;
    ras_hi = ras_n ? ras_hi + 1 : 0;
    cas_lo = cas_n ? 0 : cas_lo + 1;
    cas_hi = cas_n ? cas_hi + 1 : 0;
    p_ras = ras_n; p_cas = cas_n; p_req = ref_req;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(!ref_req && !bus_own && !ready && ras_n && cas_n, "R1 outputs in reset",
        {ref_req, bus_own, ready, ras_n, cas_n}, 5'b00011);
    @(negedge clk); rst = 1'b0; ref_gnt = 1'b1;
    @(negedge clk);
    chk(!ref_req && !ready && ras_n && cas_n, "R1 first cycle after reset",
        {ref_req, ready, ras_n, cas_n}, 4'b0011);
  endtask

  task automatic t_pause();
    int n = 1;
    while (!ref_req && n < 1000) begin @(negedge clk); n++; end
    chk(n >= PAUSE && n <= PAUSE + 4, "R2 pause length", n, PAUSE);
  endtask

  task automatic t_wake();
    int rf0 = req_falls;
    for (int i = 0; i < 2000 && !ready; i++) @(negedge clk);
    chk(ready == 1'b1, "R3 ready after wake-up", ready, 1);
    chk(cbr_cnt == WAKE, "R3 wake-up cycle count", cbr_cnt, WAKE);
    chk(req_falls == rf0, "R3 wake burst back-to-back", req_falls - rf0, 0);
  endtask

  task automatic t_interval();
    int c0 = cbr_cnt;
    for (int i = 0; i < 1000 && cbr_cnt < c0 + 3; i++) @(negedge clk);
    chk(cbr_cnt == c0 + 3, "R8 periodic refreshes", cbr_cnt - c0, 3);
    chk(spacing == IVL, "R8 refresh spacing", spacing, IVL);
  endtask

  task automatic t_ignore();
    bit quiet = 1'b1;
    for (int i = 0; i < 200 && ref_req; i++) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bus_own || !ras_n || !cas_n || ref_req) quiet = 1'b0;
    end
    chk(quiet, "R6 grant without request ignored", quiet, 1);
  endtask

  task automatic t_owed();
    int c0;
    ref_gnt = 1'b0;
    for (int i = 0; i < 500 && !ref_req; i++) @(negedge clk);
    repeat (IVL + IVL / 2) @(negedge clk);
    chk(!bus_own && ras_n && cas_n, "R10 no strobes without grant", bus_own, 0);
    chk(ready == 1'b1, "R8 ready kept with backlog", ready, 1);
    c0 = cbr_cnt;
    ref_gnt = 1'b1;
    for (int i = 0; i < 500 && ref_req; i++) @(negedge clk);
    chk(!ref_req && cbr_cnt - c0 == 2, "R8 backlog drained back-to-back", cbr_cnt - c0, 2);
  endtask

  task automatic t_miss();
    int c0;
    ref_gnt = 1'b0;
    for (int i = 0; i < 500 && !ref_req; i++) @(negedge clk);
    repeat (3 * IVL + IVL / 2) @(negedge clk);
    chk(ready == 1'b0, "R9 ready dropped on missed deadline", ready, 0);
    c0 = cbr_cnt;
    ref_gnt = 1'b1;
    for (int i = 0; i < 2000 && !ready; i++) @(negedge clk);
    chk(ready == 1'b1, "R9 ready after re-wake", ready, 1);
    chk(cbr_cnt - c0 == WAKE, "R9 re-wake cycle count", cbr_cnt - c0, WAKE);
  endtask

  task automatic t_timing();
    chk(v_csr == 0, "R4 CAS setup before RAS", v_csr, 0);
    chk(v_lone == 0, "R4 RAS low without CAS", v_lone, 0);
    chk(v_ras == 0, "R5 RAS low width", v_ras, 0);
    chk(v_rp == 0, "R5 RAS precharge", v_rp, 0);
    chk(v_cp == 0, "R7 CAS precharge", v_cp, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_pause();
    t_wake();
    t_interval();
    t_ignore();
    t_owed();
    t_miss();
    t_interval();
    t_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule